// File: doc/BRIEF.md
# Dual-file address generation unit

This block produces two memory addresses per clock for a signal-processing datapath. It holds eight pointer triplets. Each triplet has a 16-bit address register (Rn), a 16-bit offset register (Nn) and a 16-bit modifier register (Mn). Triplets 0 to 3 form the lower file and triplets 4 to 7 form the upper file. Each file has its own arithmetic unit, so one lower and one upper pointer can be used and advanced in the same cycle.

For each file, the controller supplies three things: a 2-bit triplet select, a 3-bit mode code and an update enable. It also supplies a bus-steer bit that places the file's address on the X or the Y address bus. The modifier register of the selected triplet picks the arithmetic:
- linear;
- circular, inside a buffer whose length is the modifier plus one;
- reverse-carry, which gives bit-reversed FFT orderings.

Three independent write ports load any register. These are the global data bus and the X and Y data buses. Address outputs are combinational from the current register state. Write-back happens at the rising clock edge.

Top module: `agu_dual`

## Requirements
- R1: After an asynchronous active-low reset, every Rn and Nn reads 0 and every Mn is 0xFFFF (linear).
- R2: Each write port (gdb, xdb, ydb) writes register kind 0=Rn, 1=Nn, 2=Mn (3 = no write) at triplet index 0..7 at the clock edge. When several ports hit the same register, gdb wins over xdb, and xdb wins over ydb.
- R3: Mode codes select the bus value:
  - 0 = no update and 7 = reserved: the old Rn;
  - 1 = post +1, 2 = post -1, 3 = post +Nn, 4 = post -Nn: the old Rn;
  - 5 = indexed (Rn+Nn) and 6 = pre-decrement: the computed value.
- R4: The computed value is written to Rn only when the file's update enable is 1 and the mode is 1, 2, 3, 4 or 6. Modes 0, 5 and 7 never change Rn.
- R5: An Mn of 0xFFFF, or any value with bit 15 set other than 0, gives plain two's-complement add or subtract modulo 2^16.
- R6: An Mn of 1..0x7FFF gives circular arithmetic. The buffer length is L = Mn+1. The buffer base is Rn with its low k bits cleared, where 2^k is the smallest power of two of at least L. A step of at most L that leaves the buffer wraps back by L.
- R7: An Mn of 0 gives reverse-carry arithmetic, in which the carry or borrow travels from bit 15 toward bit 0.
- R8: A file uses only the Nn and Mn of its selected triplet. Both files compute and write back in the same cycle, independently.
- R9: A bus-steer bit of 0 selects the X bus and 1 selects the Y bus. A bus that no file selects reads 0. When both files select the same bus, the lower file drives it and bus_clash is 1; otherwise bus_clash is 0.
- R10: A port write to an Rn in the same cycle as that Rn's write-back leaves the port's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gdb_we | input | 1 | Global bus write enable |
| gdb_kind | input | 2 | Global bus target kind (0 Rn, 1 Nn, 2 Mn) |
| gdb_idx | input | 3 | Global bus target triplet |
| gdb_data | input | 16 | Global bus write data |
| xdb_we | input | 1 | X data bus write enable |
| xdb_kind | input | 2 | X data bus target kind |
| xdb_idx | input | 3 | X data bus target triplet |
| xdb_data | input | 16 | X data bus write data |
| ydb_we | input | 1 | Y data bus write enable |
| ydb_kind | input | 2 | Y data bus target kind |
| ydb_idx | input | 3 | Y data bus target triplet |
| ydb_data | input | 16 | Y data bus write data |
| lo_sel | input | 2 | Lower file triplet select (0..3) |
| lo_mode | input | 3 | Lower file mode code |
| lo_upd | input | 1 | Lower file write-back enable |
| lo_bsel | input | 1 | Lower file bus steer (0 X, 1 Y) |
| hi_sel | input | 2 | Upper file triplet select (4..7) |
| hi_mode | input | 3 | Upper file mode code |
| hi_upd | input | 1 | Upper file write-back enable |
| hi_bsel | input | 1 | Upper file bus steer (0 X, 1 Y) |
| xab | output | 16 | X address bus |
| yab | output | 16 | Y address bus |
| bus_clash | output | 1 | Both files requested the same bus |

## Verification
All eight mode codes are swept over all eight triplets, with the upper file running the mirrored mode, so each cycle exercises two mode paths at once.

The sweeps use three modifier classes:
- Linear sweeps, run with and without update enable, separate old-value from new-value output and show which modes write back.
- Circular sweeps use buffers of 2, 8, 16 and 20 entries, with steps up to the full length. They reach both the upper and the lower wrap.
- Reverse-carry runs with offset 8 reproduce the 64, 72, 68, 76, 66 order, and run with negative and unit steps.

Directed cycles cover bus clashes, write-port priority, and a port write colliding with a write-back.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [2:0] {
      MD_HOLD    = 3'd0,
      MD_POSTINC = 3'd1,
      MD_POSTDEC = 3'd2,
      MD_POSTADD = 3'd3,
      MD_POSTSUB = 3'd4,
      MD_INDEX   = 3'd5,
      MD_PREDEC  = 3'd6,
      MD_SPARE   = 3'd7
   } agu_mode_e;

   typedef enum logic [1:0] {
      RK_PTR  = 2'd0,
      RK_OFS  = 2'd1,
      RK_MOD  = 2'd2,
      RK_NONE = 2'd3
   } agu_kind_e;

   localparam int unsigned NUM_WPORTS = 3;
endpackage

// File: rtl/agu_arith.sv
module agu_arith #(
   parameter int unsigned AW          = 16,
   parameter bit          HAS_REVERSE = 1'b1
) (
   input  logic [AW-1:0] r_i,
   input  logic [AW-1:0] n_i,
   input  logic [AW-1:0] m_i,
   input  logic [2:0]    mode_i,
   output logic [AW-1:0] addr_o,
   output logic [AW-1:0] nxt_o,
   output logic          wb_o
);
   import agu_pkg::*;

   agu_mode_e     md;
   logic          use_n, sub, is_rev, is_mod;
   logic [AW-1:0] mag, lin, circ, rc, calc, mask, lower;
   logic [AW:0]   upper, span, absw;

   assign md = agu_mode_e'(mode_i);

   always_comb begin
      use_n = md inside {MD_POSTADD, MD_POSTSUB, MD_INDEX};
      sub   = md inside {MD_POSTDEC, MD_POSTSUB, MD_PREDEC};
      mag   = use_n ? n_i : AW'(1);
      lin   = sub ? (r_i - mag) : (r_i + mag);
   end

   // circular buffer: base aligned to next power of two above modifier
   always_comb begin
      mask = m_i;
      for (int i = 1; i < AW; i++) mask = mask | (mask >> i);
      lower = r_i & ~mask;
      upper = {1'b0, lower} + {1'b0, m_i};
      span  = {1'b0, m_i} + 1'b1;
      absw  = sub ? ({1'b0, r_i} - {1'b0, mag}) : ({1'b0, r_i} + {1'b0, mag});
      if (sub && (absw[AW] || (absw < {1'b0, lower})))
         circ = AW'(absw + span);
      else if (!sub && (absw > upper))
         circ = AW'(absw - span);
      else
         circ = AW'(absw);
   end

   function automatic logic [AW-1:0] brev(input logic [AW-1:0] v);
      for (int i = 0; i < AW; i++) brev[i] = v[AW-1-i];
   endfunction

   if (HAS_REVERSE) begin : g_rev
      assign rc = brev(sub ? (brev(r_i) - brev(mag)) : (brev(r_i) + brev(mag)));
   end else begin : g_norev
      assign rc = lin;
   end

   always_comb begin
      is_rev = (m_i == '0);
      is_mod = !m_i[AW-1] && !is_rev;
      calc   = is_rev ? rc : (is_mod ? circ : lin);
      addr_o = (md inside {MD_INDEX, MD_PREDEC}) ? calc : r_i;
      nxt_o  = calc;
      wb_o   = md inside {MD_POSTINC, MD_POSTDEC, MD_POSTADD, MD_POSTSUB, MD_PREDEC};
   end
endmodule

// File: rtl/agu_regfile.sv
module agu_regfile #(
   parameter int unsigned AW    = 16,
   parameter int unsigned TPF   = 4,
   parameter int unsigned BASE  = 0,
   parameter int unsigned IDX_W = 3,
   parameter int unsigned NWP   = 3,
   localparam int unsigned SEL_W = $clog2(TPF)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NWP-1:0]                wp_we,
   input  logic [NWP-1:0][1:0]           wp_kind,
   input  logic [NWP-1:0][IDX_W-1:0]     wp_idx,
   input  logic [NWP-1:0][AW-1:0]        wp_data,
   input  logic [SEL_W-1:0]              sel_i,
   input  logic                          upd_en_i,
   input  logic [AW-1:0]                 upd_val_i,
   output logic [AW-1:0]                 r_o,
   output logic [AW-1:0]                 n_o,
   output logic [AW-1:0]                 m_o,
   output logic [TPF-1:0][AW-1:0]        r_all_o
);
   import agu_pkg::*;

   logic [AW-1:0] r_q [TPF];
   logic [AW-1:0] n_q [TPF];
   logic [AW-1:0] m_q [TPF];

   for (genvar t = 0; t < TPF; t++) begin : g_trip
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(BASE + t);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_q[t] <= '0;
            n_q[t] <= '0;
            m_q[t] <= '1;
         end else begin
            if (upd_en_i && (sel_i == SEL_W'(t))) r_q[t] <= upd_val_i;
            // last assignment wins: port 0 (global bus) has top priority
            for (int p = NWP - 1; p >= 0; p--) begin
               if (wp_we[p] && (wp_idx[p] == MY_IDX)) begin
                  case (agu_kind_e'(wp_kind[p]))
                     RK_PTR:  r_q[t] <= wp_data[p];
                     RK_OFS:  n_q[t] <= wp_data[p];
                     RK_MOD:  m_q[t] <= wp_data[p];
                     default: ;
                  endcase
               end
            end
         end
      end
      assign r_all_o[t] = r_q[t];
   end

   assign r_o = r_q[sel_i];
   assign n_o = n_q[sel_i];
   assign m_o = m_q[sel_i];
endmodule

// File: rtl/agu_dual.sv
module agu_dual #(
   parameter int unsigned AW          = 16,
   parameter int unsigned TPF         = 4,
   parameter bit          HAS_REVERSE = 1'b1,
   localparam int unsigned SEL_W = $clog2(TPF),
   localparam int unsigned NTRIP = 2 * TPF,
   localparam int unsigned IDX_W = $clog2(NTRIP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gdb_we,
   input  logic [1:0]       gdb_kind,
   input  logic [IDX_W-1:0] gdb_idx,
   input  logic [AW-1:0]    gdb_data,
   input  logic             xdb_we,
   input  logic [1:0]       xdb_kind,
   input  logic [IDX_W-1:0] xdb_idx,
   input  logic [AW-1:0]    xdb_data,
   input  logic             ydb_we,
   input  logic [1:0]       ydb_kind,
   input  logic [IDX_W-1:0] ydb_idx,
   input  logic [AW-1:0]    ydb_data,
   input  logic [SEL_W-1:0] lo_sel,
   input  logic [2:0]       lo_mode,
   input  logic             lo_upd,
   input  logic             lo_bsel,
   input  logic [SEL_W-1:0] hi_sel,
   input  logic [2:0]       hi_mode,
   input  logic             hi_upd,
   input  logic             hi_bsel,
   output logic [AW-1:0]    xab,
   output logic [AW-1:0]    yab,
   output logic             bus_clash
);
   import agu_pkg::*;

   if (AW < 4) begin : g_bad_aw
      $error("agu_dual: AW must be at least 4");
   end
   if ((TPF < 2) || ((1 << SEL_W) != TPF)) begin : g_bad_tpf
      $error("agu_dual: TPF must be a power of two, at least 2");
   end

   logic [NUM_WPORTS-1:0]                wp_we;
   logic [NUM_WPORTS-1:0][1:0]           wp_kind;
   logic [NUM_WPORTS-1:0][IDX_W-1:0]     wp_idx;
   logic [NUM_WPORTS-1:0][AW-1:0]        wp_data;
   logic [NTRIP-1:0][AW-1:0]             r_all;

   // port 0 = global bus (highest priority), 1 = X data, 2 = Y data
   assign wp_we   = {ydb_we,   xdb_we,   gdb_we};
   assign wp_kind = {ydb_kind, xdb_kind, gdb_kind};
   assign wp_idx  = {ydb_idx,  xdb_idx,  gdb_idx};
   assign wp_data = {ydb_data, xdb_data, gdb_data};

   logic [1:0][SEL_W-1:0] f_sel;
   logic [1:0][2:0]       f_mode;
   logic [1:0]            f_upd;
   logic [AW-1:0]         f_addr [2];

   assign f_sel  = {hi_sel, lo_sel};
   assign f_mode = {hi_mode, lo_mode};
   assign f_upd  = {hi_upd, lo_upd};

   for (genvar f = 0; f < 2; f++) begin : g_file
      logic [AW-1:0] r_s, n_s, m_s, nxt;
      logic          wb;

      agu_regfile #(
         .AW(AW), .TPF(TPF), .BASE(f * TPF), .IDX_W(IDX_W), .NWP(NUM_WPORTS)
      ) u_rf (
         .clk       (clk),
         .rst_n     (rst_n),
         .wp_we     (wp_we),
         .wp_kind   (wp_kind),
         .wp_idx    (wp_idx),
         .wp_data   (wp_data),
         .sel_i     (f_sel[f]),
         .upd_en_i  (wb && f_upd[f]),
         .upd_val_i (nxt),
         .r_o       (r_s),
         .n_o       (n_s),
         .m_o       (m_s),
         .r_all_o   (r_all[f*TPF +: TPF])
      );

      agu_arith #(.AW(AW), .HAS_REVERSE(HAS_REVERSE)) u_alu (
         .r_i    (r_s),
         .n_i    (n_s),
         .m_i    (m_s),
         .mode_i (f_mode[f]),
         .addr_o (f_addr[f]),
         .nxt_o  (nxt),
         .wb_o   (wb)
      );
   end

   always_comb begin
      if (!lo_bsel)      xab = f_addr[0];
      else if (!hi_bsel) xab = f_addr[1];
      else               xab = '0;
      if (lo_bsel)       yab = f_addr[0];
      else if (hi_bsel)  yab = f_addr[1];
      else               yab = '0;
      bus_clash = (lo_bsel == hi_bsel);
   end
endmodule

// File: rtl/agu_dual_chk.sv
module agu_dual_chk #(
   parameter int unsigned AW  = 16,
   parameter int unsigned TPF = 4,
   localparam int unsigned SEL_W = $clog2(TPF),
   localparam int unsigned NTRIP = 2 * TPF,
   localparam int unsigned IDX_W = $clog2(NTRIP)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    gdb_we,
   input logic [1:0]              gdb_kind,
   input logic [IDX_W-1:0]        gdb_idx,
   input logic [AW-1:0]           gdb_data,
   input logic                    xdb_we,
   input logic [1:0]              xdb_kind,
   input logic [IDX_W-1:0]        xdb_idx,
   input logic                    ydb_we,
   input logic [1:0]              ydb_kind,
   input logic [IDX_W-1:0]        ydb_idx,
   input logic [SEL_W-1:0]        lo_sel,
   input logic [2:0]              lo_mode,
   input logic                    lo_upd,
   input logic                    lo_bsel,
   input logic                    hi_bsel,
   input logic [AW-1:0]           xab,
   input logic [AW-1:0]           yab,
   input logic                    bus_clash,
   input logic [NTRIP-1:0][AW-1:0] r_all
);
   logic lo_ptr_wr, lo_no_wb;

   assign lo_ptr_wr = (gdb_we && gdb_kind == 2'd0 && !gdb_idx[IDX_W-1]) ||
                      (xdb_we && xdb_kind == 2'd0 && !xdb_idx[IDX_W-1]) ||
                      (ydb_we && ydb_kind == 2'd0 && !ydb_idx[IDX_W-1]);
   assign lo_no_wb  = !lo_upd || (lo_mode == 3'd0) || (lo_mode == 3'd5) || (lo_mode == 3'd7);

   p_reset_ptrs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (r_all == '0));

   p_gdb_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gdb_we && gdb_kind == 2'd0) |=> (r_all[$past(gdb_idx)] == $past(gdb_data)));

   p_lower_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_no_wb && !lo_ptr_wr) |=> $stable(r_all[TPF-1:0]));

   p_hold_shows_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_mode == 3'd0 && !lo_bsel) |-> (xab == r_all[lo_sel]));

   p_idle_bus_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_clash |-> ((lo_bsel ? xab : yab) == '0));

   p_clash_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_bsel != hi_bsel) |-> !bus_clash);
endmodule

bind agu_dual agu_dual_chk #(.AW(AW), .TPF(TPF)) u_chk (.*);

// File: tb/agu_dual_tb.sv
module agu_dual_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gdb_we = 0, xdb_we = 0, ydb_we = 0;
   logic [1:0]  gdb_kind = 0, xdb_kind = 0, ydb_kind = 0;
   logic [2:0]  gdb_idx = 0, xdb_idx = 0, ydb_idx = 0;
   logic [15:0] gdb_data = 0, xdb_data = 0, ydb_data = 0;
   logic [1:0]  lo_sel = 0, hi_sel = 0;
   logic [2:0]  lo_mode = 0, hi_mode = 0;
   logic        lo_upd = 0, hi_upd = 0, lo_bsel = 0, hi_bsel = 1;
   logic [15:0] xab, yab;
   logic        bus_clash;

   int n_vec = 0, n_bad = 0;
   logic [15:0] mr [8];
   logic [15:0] mn [8];
   logic [15:0] mm [8];

   always #10 clk = ~clk;

   agu_dual u_dut (.*);

   task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] rc_add(logic [15:0] a, logic [15:0] b, bit neg);
      int c = 0;
      logic [15:0] s;
      for (int i = 15; i >= 0; i--) begin
         int d = neg ? (int'(a[i]) - int'(b[i]) - c) : (int'(a[i]) + int'(b[i]) + c);
         if (neg) begin s[i] = d[0]; c = (d < 0) ? 1 : 0; end
         else     begin s[i] = d[0]; c = d >> 1; end
      end
      return s;
   endfunction

   function automatic logic [15:0] e_calc(logic [15:0] r, logic [15:0] n, logic [15:0] m, logic [2:0] md);
      bit neg = (md == 2 || md == 4 || md == 6);
      logic [15:0] mag = (md == 3 || md == 4 || md == 5) ? n : 16'd1;
      if (m == 0) return rc_add(r, mag, neg);
      if (m < 16'h8000) begin
         int size = int'(m) + 1;
         int k = 0;
         int base, pos, np;
         while ((1 << k) < size) k++;
         base = (int'(r) >> k) << k;
         pos = int'(r) - base;
         np = neg ? pos - int'(mag) : pos + int'(mag);
         np = ((np % size) + size) % size;
         return 16'(base + np);
      end
      return neg ? r - mag : r + mag;
   endfunction

   function automatic bit e_wb(logic [2:0] md);
      return md inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd6};
   endfunction

   function automatic logic [15:0] e_out(logic [15:0] r, logic [15:0] n, logic [15:0] m, logic [2:0] md);
      return (md == 5 || md == 6) ? e_calc(r, n, m, md) : r;
   endfunction

   task automatic model_wr(logic we, logic [1:0] k, logic [2:0] i, logic [15:0] d);
      if (we) case (k)
         2'd0: mr[i] = d;
         2'd1: mn[i] = d;
         2'd2: mm[i] = d;
         default: ;
      endcase
   endtask

   // inputs set at negedge by caller; outputs sampled mid-low phase
   task automatic cyc(string tag);
      int li = int'(lo_sel), hj = 4 + int'(hi_sel);
      logic [15:0] lo_v, hi_v, x_e, y_e, lo_n, hi_n;
      #5;
      lo_v = e_out(mr[li], mn[li], mm[li], lo_mode);
      hi_v = e_out(mr[hj], mn[hj], mm[hj], hi_mode);
      lo_n = e_calc(mr[li], mn[li], mm[li], lo_mode);
      hi_n = e_calc(mr[hj], mn[hj], mm[hj], hi_mode);
      x_e = !lo_bsel ? lo_v : (!hi_bsel ? hi_v : 16'h0);
      y_e =  lo_bsel ? lo_v : ( hi_bsel ? hi_v : 16'h0);
      chk(tag, "xab", xab, x_e);
      chk(tag, "yab", yab, y_e);
      chk(tag, "bus_clash", {15'h0, bus_clash}, {15'h0, lo_bsel == hi_bsel});
      @(posedge clk);
      if (lo_upd && e_wb(lo_mode)) mr[li] = lo_n;
      if (hi_upd && e_wb(hi_mode)) mr[hj] = hi_n;
      model_wr(ydb_we, ydb_kind, ydb_idx, ydb_data);
      model_wr(xdb_we, xdb_kind, xdb_idx, xdb_data);
      model_wr(gdb_we, gdb_kind, gdb_idx, gdb_data);
      @(negedge clk);
      gdb_we = 0; xdb_we = 0; ydb_we = 0;
   endtask

   task automatic load(int t, logic [15:0] r, logic [15:0] n, logic [15:0] m);
      lo_mode = 0; hi_mode = 0; lo_upd = 0; hi_upd = 0;
      gdb_we = 1; gdb_kind = 2'd0; gdb_idx = 3'(t); gdb_data = r;
      xdb_we = 1; xdb_kind = 2'd1; xdb_idx = 3'(t); xdb_data = n;
      ydb_we = 1; ydb_kind = 2'd2; ydb_idx = 3'(t); ydb_data = m;
      cyc("R2");
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      for (int t = 0; t < 8; t++) begin mr[t] = 0; mn[t] = 0; mm[t] = 16'hFFFF; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset contents, seen through hold mode
      for (int s = 0; s < 4; s++) begin
         lo_sel = 2'(s); hi_sel = 2'(s); lo_bsel = 0; hi_bsel = 1;
         cyc("R1");
         chk("R1", "xab", xab, 16'h0);
         chk("R1", "yab", yab, 16'h0);
      end

      // R5 linear (incl. M with bit 15 set) / R3 / R4 / R8 sweep
      for (int pass = 0; pass < 2; pass++) begin
         for (int t = 0; t < 8; t++)
            load(t, 16'(16'h1000 * t + 16'h0F7 * t + 3), 16'(t * 3 + 1), (t == 3 || t == 6) ? 16'h9000 : 16'hFFFF);
         for (int md = 0; md < 8; md++)
            for (int s = 0; s < 4; s++) begin
               lo_sel = 2'(s); hi_sel = 2'(3 - s);
               lo_mode = 3'(md); hi_mode = 3'(7 - md);
               lo_upd = (pass == 0); hi_upd = (pass == 0);
               lo_bsel = s[0]; hi_bsel = !s[0];
               cyc(pass == 0 ? "R3" : "R4");
               lo_mode = 0; hi_mode = 0;
               cyc("R5");
            end
      end

      // R6 circular buffers of length 20, 16, 8, 2
      for (int t = 0; t < 8; t++) begin
         logic [15:0] mv;
         case (t % 4) 0: mv = 19; 1: mv = 15; 2: mv = 7; default: mv = 1; endcase
         load(t, 16'(64 + (t * 5) % (int'(mv) + 1)), 16'((t * 7) % (int'(mv) + 1) + 1), mv);
      end
      for (int rep = 0; rep < 4; rep++)
         for (int md = 1; md < 7; md++)
            for (int s = 0; s < 4; s++) begin
               lo_sel = 2'(s); hi_sel = 2'(s);
               lo_mode = 3'(md); hi_mode = 3'(7 - md);
               lo_upd = 1; hi_upd = 1; lo_bsel = 0; hi_bsel = 1;
               cyc("R6");
            end
      load(0, 16'd75, 16'd5, 16'd19);
      lo_sel = 0; lo_mode = 3; lo_upd = 1; hi_mode = 0;
      cyc("R6"); cyc("R6");
      lo_mode = 0; cyc("R6");
      chk("R6", "wrapped ptr", xab, 16'd65);

      // R7 reverse-carry
      load(1, 16'd64, 16'd8, 16'h0);
      load(5, 16'd64, 16'd8, 16'h0);
      lo_sel = 1; hi_sel = 1; lo_upd = 1; hi_upd = 1; lo_bsel = 0; hi_bsel = 1;
      lo_mode = 3; hi_mode = 4;
      cyc("R7");
      lo_mode = 0; hi_mode = 0; cyc("R7");
      chk("R7", "rev step", xab, 16'd72);
      for (int rep = 0; rep < 6; rep++) begin
         lo_mode = 3'(rep % 2 == 0 ? 3 : 1); hi_mode = 3'(rep % 2 == 0 ? 4 : 2);
         cyc("R7");
      end
      lo_mode = 6; hi_mode = 5; cyc("R7");

      // R8 same pointer values, different per-file offsets
      load(2, 16'd100, 16'd3, 16'hFFFF);
      load(6, 16'd100, 16'd7, 16'hFFFF);
      lo_sel = 2; hi_sel = 2; lo_mode = 5; hi_mode = 5; lo_upd = 1; hi_upd = 1;
      cyc("R8");
      chk("R8", "lower idx", xab, 16'd103);
      chk("R8", "upper idx", yab, 16'd107);
      lo_mode = 3; hi_mode = 4; cyc("R8");
      lo_mode = 0; hi_mode = 0; cyc("R8");

      // R9 clash on both buses
      lo_mode = 0; hi_mode = 6; lo_bsel = 0; hi_bsel = 0; cyc("R9");
      lo_bsel = 1; hi_bsel = 1; cyc("R9");
      lo_bsel = 0; hi_bsel = 1; hi_mode = 0;

      // R10 port write beats write-back of the same pointer
      lo_sel = 0; lo_mode = 1; lo_upd = 1;
      gdb_we = 1; gdb_kind = 0; gdb_idx = 0; gdb_data = 16'hBEEF;
      cyc("R10");
      lo_mode = 0; cyc("R10");
      chk("R10", "ptr", xab, 16'hBEEF);

      // R2 port priority on one target
      hi_sel = 0; hi_mode = 0;
      gdb_we = 1; gdb_kind = 0; gdb_idx = 4; gdb_data = 16'h1111;
      xdb_we = 1; xdb_kind = 0; xdb_idx = 4; xdb_data = 16'h2222;
      ydb_we = 1; ydb_kind = 0; ydb_idx = 4; ydb_data = 16'h3333;
      cyc("R2");
      cyc("R2");
      chk("R2", "gdb wins", yab, 16'h1111);
      xdb_we = 1; xdb_kind = 0; xdb_idx = 4; xdb_data = 16'h2222;
      ydb_we = 1; ydb_kind = 0; ydb_idx = 4; ydb_data = 16'h3333;
      cyc("R2");
      cyc("R2");
      chk("R2", "xdb wins", yab, 16'h2222);
      ydb_we = 1; ydb_kind = 3; ydb_idx = 4; ydb_data = 16'h4444;
      cyc("R2");
      cyc("R2");
      chk("R2", "kind 3 no write", yab, 16'h2222);

      finish_run();
   end
endmodule